// File: doc/BRIEF.md
# Segment LCD Frame and Refresh Timing Generator

This block turns a slow input clock into the timing pulses that a segment LCD driver needs. A power-of-two prescaler feeds a divide-by-(N+1) stage. Together they produce one pulse per common-line slot. A common-line index steps through the configured number of commons, and a frame pulse marks each return to the first common. Two further pulses come from an external 2 kHz base tick. One paces the bias reference refresh and the other paces the charge pump refresh, and each has its own rate select.

All configuration arrives on static input fields. The three fields that shape the frame are the prescaler select, the divider value and the duty code. The block copies them into a shadow set while it is disabled and at every frame boundary, so a frame already in progress always finishes with the settings it started with. The two refresh selects act on their counters directly.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released with `enable` low, `com_tick`, `frame_strobe`, `ref_strobe` and `pump_strobe` are 0 and `com_idx` is 0.
- R2: The prescaler select `presc_sel` divides the clock by 16, 32, 64 or 128 for codes 0, 1, 2 and 3.
- R3: The divider value `clk_div` adds a further division by `clk_div`+1. `com_tick` is therefore a one-cycle pulse every P·(`clk_div`+1) cycles, where P is the prescaler ratio. The first pulse is visible P·(`clk_div`+1) cycles after `enable` rises.
- R4: The duty code `duty_sel` sets the number of commons N: code 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 6, and codes 5, 6 and 7 give 8. `com_idx` advances by one on each `com_tick` and wraps to 0 after N-1.
- R5: `frame_strobe` is a one-cycle pulse in the same cycle as the `com_tick` on which `com_idx` wraps to 0. It repeats every N·P·(`clk_div`+1) cycles.
- R6: `ref_strobe` pulses once every 2^s base ticks, where s is the value of `ref_sel`. Codes 6 and 7 act as code 5.
- R7: `pump_strobe` pulses once every 2^s base ticks, where s is the value of `pump_sel` (0 to 3).
- R8: While `enable` is low, no strobe is produced and `com_idx` stays 0.
- R9: A change to `presc_sel`, `clk_div` or `duty_sel` while enabled takes effect only at the next `frame_strobe`. The current frame finishes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low clears all counters |
| presc_sel | input | 2 | Prescaler select (16/32/64/128) |
| clk_div | input | 3 | Divider value, divides by value+1 |
| duty_sel | input | 3 | Number-of-commons code |
| ref_sel | input | 3 | Bias reference refresh rate code |
| pump_sel | input | 2 | Charge pump refresh rate code |
| base_tick | input | 1 | One-cycle 2 kHz base pulse |
| com_tick | output | 1 | Pulse per common-line slot |
| com_idx | output | 3 | Current common line |
| frame_strobe | output | 1 | End-of-frame pulse |
| ref_strobe | output | 1 | Bias reference refresh pulse |
| pump_strobe | output | 1 | Charge pump refresh pulse |

## Verification
The common-line pulse period is measured for three prescaler and divider pairs. The smallest, a mixed pair and the largest together separate a wrong prescaler ratio from a wrong off-by-one in the divider. Every duty code, including the two aliased codes, is run with the number of slots per frame, the highest index and the frame length measured, which exposes a wrong common count or a wrong wrap point. Every refresh code is run against a fixed base-tick spacing, with the clamped codes included. A configuration change in the middle of a frame, followed by the next two frame lengths, shows whether the change was deferred to the frame boundary or applied at once.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int PSEL_W          = 2;
    localparam int DIV_W           = 3;
    localparam int DUTY_W          = 3;
    localparam int IDX_W           = 3;
    localparam int REF_W           = 3;
    localparam int PUMP_W          = 2;
    localparam int REF_MAX_CODE    = 5;
    localparam int PUMP_MAX_CODE   = 3;
    localparam int PRESC_BASE_LOG2 = 4;
    localparam int PCNT_W          = PRESC_BASE_LOG2 + (1 << PSEL_W) - 1;

    typedef struct packed {
        logic [PSEL_W-1:0] presc;
        logic [DIV_W-1:0]  div;
        logic [DUTY_W-1:0] duty;
    } frame_cfg_t;

    // Terminal value of the prescaler counter for a select code
    function automatic logic [PCNT_W-1:0] presc_last(input logic [PSEL_W-1:0] sel);
        int ratio;
        ratio = 1 << (PRESC_BASE_LOG2 + int'(sel));
        return PCNT_W'(ratio - 1);
    endfunction

    // Highest common index for a duty code
    function automatic logic [IDX_W-1:0] last_com(input logic [DUTY_W-1:0] code);
        logic [IDX_W-1:0] r;
        case (code)
            3'd0:    r = 3'd0;
            3'd1:    r = 3'd1;
            3'd2:    r = 3'd2;
            3'd3:    r = 3'd3;
            3'd4:    r = 3'd5;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PSEL_W-1:0] presc,
    input  logic [DIV_W-1:0]  div,
    output logic              tick_now
);

    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
        logic [DIV_W-1:0]  dcnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        tick_now = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (st_q.pcnt >= presc_last(presc)) begin
            st_d.pcnt = '0;
            if (st_q.dcnt >= div) begin
                st_d.dcnt = '0;
                tick_now  = 1'b1;
            end else begin
                st_d.dcnt = DIV_W'(st_q.dcnt + 1'b1);
            end
        end else begin
            st_d.pcnt = PCNT_W'(st_q.pcnt + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lcdt_com_seq.sv
module lcdt_com_seq
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick_now,
    input  logic [IDX_W-1:0] last_idx,
    output logic             wrap_now,
    output logic             com_tick,
    output logic             frame_strobe,
    output logic [IDX_W-1:0] com_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             tick;
        logic             frame;
    } seq_state_t;

    seq_state_t st_d, st_q;

    assign wrap_now = enable && tick_now && (st_q.idx >= last_idx);

    always_comb begin
        st_d       = st_q;
        st_d.tick  = 1'b0;
        st_d.frame = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (tick_now) begin
            st_d.tick = 1'b1;
            if (st_q.idx >= last_idx) begin
                st_d.idx   = '0;
                st_d.frame = 1'b1;
            end else begin
                st_d.idx = IDX_W'(st_q.idx + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_tick     = st_q.tick;
    assign frame_strobe = st_q.frame;
    assign com_idx      = st_q.idx;

endmodule

// File: rtl/lcdt_refresh.sv
module lcdt_refresh #(
    parameter int SEL_W    = 3,
    parameter int MAX_CODE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             base_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             strobe
);

    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } ref_state_t;

    ref_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        int eff;
        eff   = (int'(sel) > MAX_CODE) ? MAX_CODE : int'(sel);
        limit = CNT_W'((1 << eff) - 1);
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (base_tick) begin
            if (st_q.cnt >= limit) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = CNT_W'(st_q.cnt + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.pulse;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [DUTY_W-1:0] duty_sel,
    input  logic [REF_W-1:0]  ref_sel,
    input  logic [PUMP_W-1:0] pump_sel,
    input  logic              base_tick,
    output logic              com_tick,
    output logic [IDX_W-1:0]  com_idx,
    output logic              frame_strobe,
    output logic              ref_strobe,
    output logic              pump_strobe
);

    frame_cfg_t cfg_d, cfg_q;
    logic       tick_now;
    logic       wrap_now;

    // Shadow frame settings: follow inputs while idle, reload at frame end
    always_comb begin
        cfg_d = cfg_q;
        if (!enable || wrap_now) begin
            cfg_d.presc = presc_sel;
            cfg_d.div   = clk_div;
            cfg_d.duty  = duty_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    lcdt_clkdiv i_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .presc    (cfg_q.presc),
        .div      (cfg_q.div),
        .tick_now (tick_now)
    );

    lcdt_com_seq i_com_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .tick_now     (tick_now),
        .last_idx     (last_com(cfg_q.duty)),
        .wrap_now     (wrap_now),
        .com_tick     (com_tick),
        .frame_strobe (frame_strobe),
        .com_idx      (com_idx)
    );

    lcdt_refresh #(.SEL_W(REF_W), .MAX_CODE(REF_MAX_CODE)) i_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .base_tick (base_tick),
        .sel       (ref_sel),
        .strobe    (ref_strobe)
    );

    lcdt_refresh #(.SEL_W(PUMP_W), .MAX_CODE(PUMP_MAX_CODE)) i_pump (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .base_tick (base_tick),
        .sel       (pump_sel),
        .strobe    (pump_strobe)
    );

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       base_tick,
    input logic       com_tick,
    input logic [2:0] com_idx,
    input logic       frame_strobe,
    input logic       ref_strobe,
    input logic       pump_strobe
);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!com_tick && !frame_strobe && !ref_strobe && !pump_strobe && com_idx == 3'd0));

    // R5
    frame_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> (com_tick && com_idx == 3'd0));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (com_tick && !frame_strobe) |-> (com_idx == 3'($past(com_idx) + 3'd1)));

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!com_tick && $past(enable)) |-> $stable(com_idx));

    // R6
    ref_from_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> ($past(base_tick) && $past(enable)));

    // R7
    pump_from_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_strobe |-> ($past(base_tick) && $past(enable)));

endmodule

bind lcd_timing_gen lcdt_checker i_lcdt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .base_tick    (base_tick),
    .com_tick     (com_tick),
    .com_idx      (com_idx),
    .frame_strobe (frame_strobe),
    .ref_strobe   (ref_strobe),
    .pump_strobe  (pump_strobe)
);

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] presc_sel = '0;
    logic [2:0] clk_div = '0;
    logic [2:0] duty_sel = '0;
    logic [2:0] ref_sel = '0;
    logic [1:0] pump_sel = '0;
    logic       base_tick = 1'b0;
    logic       com_tick;
    logic [2:0] com_idx;
    logic       frame_strobe;
    logic       ref_strobe;
    logic       pump_strobe;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    lcd_timing_gen i_lcd_timing_gen (.*);

    // base tick: one cycle high every 4 cycles
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            base_tick = 1'b1;
            @(negedge clk);
            base_tick = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int which);
        case (which)
            0:       return com_tick;
            1:       return frame_strobe;
            2:       return ref_strobe;
            default: return pump_strobe;
        endcase
    endfunction

    task automatic wait_for(input int which, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pick(which) && n < 5000);
    endtask

    task automatic start(input int p, input int d, input int du);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        presc_sel = 2'(p);
        clk_div   = 3'(d);
        duty_sel  = 3'(du);
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic test_reset();
        // R1
        check("R1 com_tick", int'(com_tick), 0);
        check("R1 frame", int'(frame_strobe), 0);
        check("R1 ref", int'(ref_strobe), 0);
        check("R1 pump", int'(pump_strobe), 0);
        check("R1 idx", int'(com_idx), 0);
    endtask

    task automatic test_tick(input int p, input int d);
        int n;
        int exp;
        exp = (16 << p) * (d + 1);
        start(p, d, 0);
        wait_for(0, n);
        check("R3 first tick", n, exp);
        wait_for(0, n);
        check("R2 R3 tick period", n, exp);
    endtask

    task automatic test_duty(input int code);
        int nc;
        int n;
        int ticks;
        int maxi;
        nc = (code < 4) ? code + 1 : (code == 4) ? 6 : 8;
        start(0, 0, code);
        wait_for(1, n);
        n = 0;
        ticks = 0;
        maxi = 0;
        do begin
            @(negedge clk);
            n++;
            if (com_tick) ticks++;
            if (int'(com_idx) > maxi) maxi = int'(com_idx);
        end while (!frame_strobe && n < 5000);
        check("R4 ticks per frame", ticks, nc);
        check("R4 max idx", maxi, nc - 1);
        check("R5 frame period", n, 16 * nc);
        check("R5 idx at frame", int'(com_idx), 0);
    endtask

    task automatic test_ref(input int code);
        int n;
        int eff;
        eff = (code > 5) ? 5 : code;
        ref_sel = 3'(code);
        wait_for(2, n);
        wait_for(2, n);
        check("R6 ref period", n, 4 << eff);
    endtask

    task automatic test_pump(input int code);
        int n;
        pump_sel = 2'(code);
        wait_for(3, n);
        wait_for(3, n);
        check("R7 pump period", n, 4 << code);
    endtask

    task automatic test_disable();
        int seen;
        seen = 0;
        enable = 1'b0;
        @(negedge clk);
        repeat (3000) begin
            @(negedge clk);
            if (com_tick || frame_strobe || ref_strobe || pump_strobe || com_idx != 3'd0)
                seen++;
        end
        // R8
        check("R8 activity while disabled", seen, 0);
    endtask

    task automatic test_defer();
        int n;
        start(0, 0, 3);
        wait_for(1, n);
        repeat (20) @(negedge clk);
        clk_div = 3'd1;
        wait_for(1, n);
        // R9: current frame keeps old length 64
        check("R9 frame finishes old length", n + 20, 64);
        wait_for(1, n);
        check("R9 next frame new length", n, 128);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_tick(0, 0);
        test_tick(1, 2);
        test_tick(3, 7);
        for (int c = 0; c < 8; c++) test_duty(c);
        for (int c = 0; c < 8; c++) test_ref(c);
        for (int c = 0; c < 4; c++) test_pump(c);
        test_disable();
        test_defer();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule